// File: doc/BRIEF.md
# SPI-Shared Four-Pin Parallel Port

This block is a four-pin general-purpose port. A small register bus programs it. Every pin has one bit in a data register and one bit in a direction register. A direction bit of 1 makes the pin an output that drives its data bit. A direction bit of 0 makes it an input, and the live pin level can be read back. Reset clears every direction bit. It leaves the data register unchanged.

The same pins also serve a serial peripheral interface. While the SPI enable input is high, pins 3 to 1 belong to the SPI: pin 3 is the serial clock, pin 2 is master-out/slave-in and pin 1 is master-in/slave-out. The block forces their direction bits from the SPI mode. Pin 0 follows its own direction bit. With the bit at 0, pin 0 is the slave-select input to the SPI. With the bit at 1, pin 0 stays a general output. When the SPI is turned off, pins 3 to 1 return to general use with whatever direction bits they hold at that moment.

The pin output value and the output enable are registered. Register reads are combinational from the address.

Top module: `port_spi_shared`

## Requirements
- R1: A synchronous reset clears all direction bits. One clock after the reset, pin_oe and pin_out are 0, and a read of the direction register at 0x2E returns 0.
- R2: A write takes effect on the clock edge where bus_we is high. Address 0x2C selects the data register and 0x2E selects the direction register. A write to any other address changes nothing.
- R3: With the SPI off, a pin whose direction bit is 1 has pin_oe high and pin_out equal to its data bit, one clock after the registers change. An input pin has pin_oe and pin_out at 0.
- R4: A read at 0x2C returns the data bit for each output pin and pin_in for each input pin. A read at any address other than 0x2C or 0x2E returns 0.
- R5: In SPI master mode, pins 3 and 2 are outputs driven from spi_drive and pin 1 is an input. A read of the direction register shows bits 3:1 as 110.
- R6: In SPI slave mode, pin 1 is an output driven from spi_drive[1] and pins 3 and 2 are inputs. A read of the direction register shows bits 3:1 as 001.
- R7: With the SPI on, a direction bit 0 of 0 makes spi_ss_n follow pin_in[0] and leaves pin 0 undriven. A direction bit 0 of 1 drives pin 0 from data bit 0 and holds spi_ss_n at 1.
- R8: While the SPI is on, writes to direction bits 3:1 have no effect and direction bit 0 stays writable.
- R9: When the SPI is turned off, direction bits 3:1 keep the values the SPI last forced. Those pins then drive from the data register.
- R10: Reset leaves the data register contents unchanged.
- R11: With the SPI off, spi_ss_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, combinational from bus_addr |
| spi_en | input | 1 | SPI enabled; takes pins 3 to 1 |
| spi_master | input | 1 | 1 for SPI master, 0 for SPI slave |
| spi_drive | input | 3 (bits 3:1) | Values the SPI drives on pins 3 to 1 |
| pin_in | input | 4 | Sampled pin levels |
| spi_ss_n | output | 1 | Slave-select level sent to the SPI |
| pin_oe | output | 4 | Registered output enable per pin |
| pin_out | output | 4 | Registered output value per pin, 0 when not enabled |

## Verification
The assertions check these on every cycle:
- the output enables one clock after reset;
- the pin directions forced in master mode and in slave mode, both at the pins and in the direction readback;
- spi_ss_n being idle while the SPI is off;
- spi_ss_n following pin 0 while slave select is active.

Some behaviours only the bench scenarios can show, because each depends on a sequence of events:
- writes blocked while the SPI holds the pins;
- the direction bits left behind after the SPI is turned off;
- data that survives a reset;
- the mixed readback of input levels and output data.

A behavioural reference model checks all outputs on every clock.

// File: rtl/port_pkg.sv
package port_pkg;
  localparam int PORT_W    = 4;
  localparam int SPI_LO    = 1;
  localparam int SPI_HI    = 3;
  localparam int SEL_PIN   = 0;
  localparam logic [7:0] DATA_OFS = 8'h2C;
  localparam logic [7:0] DIR_OFS  = 8'h2E;

  // direction bits {clock, master-out, master-in} required by the SPI mode
  function automatic logic [SPI_HI:SPI_LO] spi_dir(input logic master);
    return master ? 3'b110 : 3'b001;
  endfunction
endpackage

// File: rtl/port_regs.sv
module port_regs
  import port_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 data_we,
  input  logic                 dir_we,
  input  logic [W-1:0]         wdata,
  input  logic                 spi_en,
  input  logic [SPI_HI:SPI_LO] forced_dir,
  output logic [W-1:0]         data_q,
  output logic [W-1:0]         dir_q
);
  // data register has no reset by design
  always_ff @(posedge clk) begin
    if (data_we) data_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (spi_en) dir_q[SPI_HI:SPI_LO] <= forced_dir;
    end
  end
endmodule

// File: rtl/port_pinmux.sv
module port_pinmux
  import port_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic [W-1:0]         dir_q,
  input  logic [W-1:0]         data_q,
  input  logic                 spi_en,
  input  logic                 spi_master,
  input  logic [SPI_HI:SPI_LO] spi_drive,
  input  logic                 sel_pin_in,
  output logic [SPI_HI:SPI_LO] forced_dir,
  output logic [W-1:0]         dir_eff,
  output logic [W-1:0]         drv_val,
  output logic                 ss_n
);
  assign forced_dir = spi_dir(spi_master);

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i >= SPI_LO && i <= SPI_HI) begin : g_shared
      assign dir_eff[i] = spi_en ? forced_dir[i] : dir_q[i];
      assign drv_val[i] = spi_en ? spi_drive[i] : data_q[i];
    end else begin : g_plain
      assign dir_eff[i] = dir_q[i];
      assign drv_val[i] = data_q[i];
    end
  end

  assign ss_n = (spi_en && !dir_q[SEL_PIN]) ? sel_pin_in : 1'b1;
endmodule

// File: rtl/port_spi_shared.sv
module port_spi_shared
  import port_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFS),
  parameter logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(DIR_OFS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PORT_W-1:0]    bus_wdata,
  output logic [PORT_W-1:0]    bus_rdata,
  input  logic                 spi_en,
  input  logic                 spi_master,
  input  logic [SPI_HI:SPI_LO] spi_drive,
  input  logic [PORT_W-1:0]    pin_in,
  output logic                 spi_ss_n,
  output logic [PORT_W-1:0]    pin_oe,
  output logic [PORT_W-1:0]    pin_out
);
  localparam int W = PORT_W;

  logic                 hit_data, hit_dir;
  logic [W-1:0]         data_q, dir_q, dir_eff, drv_val;
  logic [SPI_HI:SPI_LO] forced_dir;

  assign hit_data = (bus_addr == DATA_ADDR);
  assign hit_dir  = (bus_addr == DIR_ADDR);

  port_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .data_we    (bus_we && hit_data && !rst),
    .dir_we     (bus_we && hit_dir),
    .wdata      (bus_wdata),
    .spi_en     (spi_en),
    .forced_dir (forced_dir),
    .data_q     (data_q),
    .dir_q      (dir_q)
  );

  port_pinmux #(.W(W)) u_mux (
    .dir_q      (dir_q),
    .data_q     (data_q),
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .spi_drive  (spi_drive),
    .sel_pin_in (pin_in[SEL_PIN]),
    .forced_dir (forced_dir),
    .dir_eff    (dir_eff),
    .drv_val    (drv_val),
    .ss_n       (spi_ss_n)
  );

  always_comb begin
    if (hit_data)     bus_rdata = (dir_eff & data_q) | (~dir_eff & pin_in);
    else if (hit_dir) bus_rdata = dir_eff;
    else              bus_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      pin_oe  <= dir_eff;
      pin_out <= dir_eff & drv_val;
    end
  end
endmodule

// File: rtl/port_spi_shared_chk.sv
module port_spi_shared_chk
  import port_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [7:0]        bus_addr,
  input logic [PORT_W-1:0] bus_rdata,
  input logic              spi_en,
  input logic              spi_master,
  input logic [PORT_W-1:0] pin_in,
  input logic              spi_ss_n,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pin_out
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0)); // R1

  AST_MASTER_PINS: assert property (@(posedge clk) disable iff (rst)
    (spi_en && spi_master) |=> (pin_oe[3:1] == 3'b110)); // R5

  AST_MASTER_DIR_RD: assert property (@(posedge clk) disable iff (rst)
    (spi_en && spi_master && bus_addr == DIR_OFS) |-> (bus_rdata[3:1] == 3'b110)); // R5

  AST_SLAVE_PINS: assert property (@(posedge clk) disable iff (rst)
    (spi_en && !spi_master) |=> (pin_oe[3:1] == 3'b001)); // R6

  AST_SLAVE_DIR_RD: assert property (@(posedge clk) disable iff (rst)
    (spi_en && !spi_master && bus_addr == DIR_OFS) |-> (bus_rdata[3:1] == 3'b001)); // R6

  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (spi_en && bus_addr == DIR_OFS && !bus_rdata[0]) |-> (spi_ss_n == pin_in[0])); // R7

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !spi_en |-> spi_ss_n); // R11
endmodule

bind port_spi_shared port_spi_shared_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .spi_en     (spi_en),
  .spi_master (spi_master),
  .pin_in     (pin_in),
  .spi_ss_n   (spi_ss_n),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out)
);

// File: tb/sim_port_spi_shared.sv
`timescale 1ns/100ps
module sim_port_spi_shared;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_we;
  logic [7:0] bus_addr;
  logic [3:0] bus_wdata;
  logic [3:0] bus_rdata;
  logic       spi_en, spi_master;
  logic [3:1] spi_drive;
  logic [3:0] pin_in;
  logic       spi_ss_n;
  logic [3:0] pin_oe, pin_out;

  localparam logic [7:0] A_DATA = 8'h2C;
  localparam logic [7:0] A_DIR  = 8'h2E;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  bit    live = 0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  port_spi_shared u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
    .spi_master(spi_master), .spi_drive(spi_drive), .pin_in(pin_in),
    .spi_ss_n(spi_ss_n), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // behavioural reference model
  logic [3:0] m_dir, m_data, m_oe, m_out;
  initial m_data = 4'bxxxx;

  function automatic logic [3:0] eff_dir();
    if (spi_en) return {(spi_master ? 3'b110 : 3'b001), m_dir[0]};
    return m_dir;
  endfunction

  always @(posedge clk) begin
    logic [3:0] e, v;
    live = 1;
    if (rst) begin
      m_dir = 4'h0; m_oe = 4'h0; m_out = 4'h0;
    end else begin
      e = eff_dir();
      v = spi_en ? {spi_drive, m_data[0]} : m_data;
      m_oe  = e;
      m_out = e & v;
      if (spi_en) m_dir[3:1] = spi_master ? 3'b110 : 3'b001;
      if (bus_we && bus_addr == A_DIR) begin
        m_dir[0] = bus_wdata[0];
        if (!spi_en) m_dir[3:1] = bus_wdata[3:1];
      end
      if (bus_we && bus_addr == A_DATA) m_data = bus_wdata;
    end
  end

  task automatic cmp(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] e, rd;
    if (live && !done) begin
      e = eff_dir();
      if (bus_addr == A_DATA)     rd = (e & m_data) | (~e & pin_in);
      else if (bus_addr == A_DIR) rd = e;
      else                        rd = 4'h0;
      cmp(pin_oe, m_oe, {phase, " model pin_oe"});
      cmp(pin_out, m_out, {phase, " model pin_out"});
      cmp(bus_rdata, rd, {phase, " model bus_rdata"});
      cmp({3'b000, spi_ss_n},
          {3'b000, (spi_en && !e[0]) ? pin_in[0] : 1'b1}, {phase, " model spi_ss_n"});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 0;
  endtask

  initial begin
    rst = 1; bus_we = 0; bus_addr = 8'h00; bus_wdata = 4'h0;
    spi_en = 0; spi_master = 0; spi_drive = 3'b000; pin_in = 4'b0101;
    repeat (3) tick();
    bus_addr = A_DIR;
    @(negedge clk); cmp(pin_oe, 4'h0, "R1 oe in reset"); cmp(bus_rdata, 4'h0, "R1 dir read");
    tick(); rst = 0; phase = "R2 R3 R4 gpio";
    wr(A_DATA, 4'hA); bus_addr = A_DATA;
    @(negedge clk); cmp(bus_rdata, 4'h5, "R4 inputs read pins");
    tick(); wr(A_DIR, 4'hF); tick(); bus_addr = A_DATA;
    @(negedge clk); cmp(pin_oe, 4'hF, "R3 oe"); cmp(pin_out, 4'hA, "R3 out");
    cmp(bus_rdata, 4'hA, "R4 outputs read data");
    tick(); wr(A_DIR, 4'h3); bus_addr = A_DATA;
    @(negedge clk); cmp(bus_rdata, 4'h6, "R4 mixed read");
    tick(); wr(8'h2D, 4'hF); tick(); bus_addr = 8'h2D;
    @(negedge clk); cmp(pin_oe, 4'h3, "R2 stray address"); cmp(bus_rdata, 4'h0, "R4 unmapped read");
    phase = "R10 R1 reset keeps data";
    tick(); rst = 1; tick(); tick(); rst = 0;
    @(negedge clk); cmp(pin_oe, 4'h0, "R1 oe after reset");
    tick(); wr(A_DIR, 4'hF); bus_addr = A_DATA;
    @(negedge clk); cmp(bus_rdata, 4'hA, "R10 data survives reset");
    tick(); wr(A_DATA, 4'h5); wr(A_DIR, 4'h1);
    tick(); phase = "R5 R7 master";
    spi_en = 1; spi_master = 1; spi_drive = 3'b010; bus_addr = A_DIR;
    @(negedge clk); cmp(bus_rdata, 4'hD, "R5 dir readback"); cmp({3'b0, spi_ss_n}, 4'h1, "R7 select idle in output mode");
    tick();
    @(negedge clk); cmp(pin_oe, 4'hD, "R5 oe"); cmp(pin_out, 4'h5, "R5 out");
    tick(); phase = "R8 R7 writes under SPI";
    wr(A_DIR, 4'h0); bus_addr = A_DIR;
    @(negedge clk); cmp(bus_rdata, 4'hC, "R8 dir write blocked"); cmp({3'b0, spi_ss_n}, 4'h1, "R7 select follows pin high");
    tick(); pin_in = 4'b0100;
    @(negedge clk); cmp({3'b0, spi_ss_n}, 4'h0, "R7 select follows pin low"); cmp(pin_oe, 4'hC, "R7 pin0 undriven");
    tick(); phase = "R6 slave";
    spi_master = 0; spi_drive = 3'b001; bus_addr = A_DIR;
    @(negedge clk); cmp(bus_rdata, 4'h2, "R6 dir readback");
    tick();
    @(negedge clk); cmp(pin_oe, 4'h2, "R6 oe"); cmp(pin_out, 4'h2, "R6 out");
    tick(); phase = "R9 R11 release";
    spi_en = 0;
    @(negedge clk); cmp(bus_rdata, 4'h2, "R9 dir kept"); cmp({3'b0, spi_ss_n}, 4'h1, "R11 select idle");
    tick();
    @(negedge clk); cmp(pin_oe, 4'h2, "R9 oe"); cmp(pin_out, 4'h0, "R9 out from data");
    tick(); phase = "R2 after release";
    wr(A_DIR, 4'h8); tick();
    @(negedge clk); cmp(pin_oe, 4'h8, "R2 dir writable again");
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule